// File: doc/BRIEF.md
# Ethernet MAC Control Register File

This block holds the software-visible configuration and status words of an Ethernet MAC behind a simple 32-bit, word-addressed request/response port. It stores the operating mode, the interrupt sources and their enables, the inter-frame gap settings, the frame-length limits, the collision settings, the transmit descriptor count, the control-frame mode, the management-interface words, the station address and two multicast hash words. It also opens a window onto a small descriptor RAM kept inside the block. The transmit and receive engines and the management serializer sit elsewhere. They read the fields this block drives and raise interrupt events on a set input.

Each request is taken in one cycle. The response (valid, data, error) is registered and appears exactly one cycle later. Writes answer with data 0. An access that is not word aligned, or whose offset maps to no register and lies outside the descriptor window, is refused with an error pulse.

Register offsets (bytes): mode 0x00, interrupt source 0x04, interrupt enable 0x08, frame-length limits 0x0C, transmit descriptor count 0x10, gap words 0x14/0x18/0x1C, collision 0x20, control mode 0x24, address low 0x28, address high 0x2C, hash 0x30/0x34, management words 0x38 to 0x4C. The descriptor window starts at 0x400.

Top module: `mac_regs_top`

## Requirements
- R1: After reset, the registers read back these values: mode 0x0000A000, first gap word 0x12, second gap word 0x0C, third gap word 0x12, frame-length limits 0x003C0600, collision 0x000F003F, management mode 0x64 and transmit descriptor count 0x80. Every other register reads 0.
- R2: The frame-length limits word carries the minimum length in bits 31:16 and the maximum length in bits 15:0. These fields are driven on `pkt_min_o` and `pkt_max_o`, and after reset they are 60 and 1536.
- R3: Writing the interrupt-source word clears each bit written as 1 and leaves the other bits unchanged. A bit raised on `int_set_i` in the same cycle stays set.
- R4: `irq_o` is high exactly when some interrupt-source bit and the matching enable bit are both 1.
- R5: A write to the transmit descriptor count keeps only bits 7:0. The same byte is loaded into the receive descriptor index `rx_bd_idx_o`.
- R6: A legal write to the mode word with bit 11 set restores every register and the receive index to their reset values. Descriptor RAM is left unchanged.
- R7: The address-low word holds station bytes 3,2,1,0 from bit 31 down. The address-high word holds byte 5 in bits 15:8 and byte 4 in bits 7:0, and reads 0 in bits 31:16. `mac_addr_o` is bytes 5..0 from the top.
- R8: An access at offset 0x400 + 4*k reaches descriptor RAM word k, for k below the RAM depth.
- R9: A misaligned or unmapped access returns data 0, changes no state, and raises `rsp_err` together with `rsp_valid` for that one response cycle only.
- R10: Every request is answered by `rsp_valid` exactly one cycle later. A cycle without a request gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| req_valid | input | 1 | access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | byte offset |
| req_wdata | input | 32 | write data |
| int_set_i | input | INT_W | interrupt events from the engines |
| rsp_valid | output | 1 | response for last cycle's request |
| rsp_rdata | output | 32 | read data (0 for writes and errors) |
| rsp_err | output | 1 | illegal access flag |
| irq_o | output | 1 | interrupt request |
| mode_o | output | 32 | mode word |
| pkt_min_o | output | 16 | minimum frame length |
| pkt_max_o | output | 16 | maximum frame length |
| txbd_num_o | output | 8 | transmit descriptor count |
| rx_bd_idx_o | output | 8 | receive descriptor index |
| mac_addr_o | output | 48 | station address, byte 5 on top |

## Verification
A wrong register state shows up on the next read of that offset. For the mode, limits, count, index and address fields it also shows on the field outputs one cycle after the write that caused it. A wrong interrupt-source or enable state shows on `irq_o` in the cycle after the event, write or clear. A decode fault shows in the response cycle as a wrong error flag or as stray data. It can also surface later, when a read finds a value that an illegal write should not have changed. The soft reset is checked across all fields in the cycle after the write.

// File: rtl/mac_regs_pkg.sv
// Package: shared offsets, defaults and the select type for the MAC
// register file. Assumes byte offsets and 32-bit words.
package mac_regs_pkg;

    localparam int OFS_MODE      = 'h00;
    localparam int OFS_ISRC      = 'h04;
    localparam int OFS_IMASK     = 'h08;
    localparam int OFS_PKTLEN    = 'h0C;
    localparam int OFS_TXBD      = 'h10;
    localparam int OFS_IPGT      = 'h14;
    localparam int OFS_IPGR1     = 'h18;
    localparam int OFS_IPGR2     = 'h1C;
    localparam int OFS_COLL      = 'h20;
    localparam int OFS_CTRL      = 'h24;
    localparam int OFS_MAC0      = 'h28;
    localparam int OFS_MAC1      = 'h2C;
    localparam int OFS_HASH0     = 'h30;
    localparam int OFS_HASH1     = 'h34;
    localparam int OFS_MG_MODE   = 'h38;
    localparam int OFS_MG_CMD    = 'h3C;
    localparam int OFS_MG_ADDR   = 'h40;
    localparam int OFS_MG_TX     = 'h44;
    localparam int OFS_MG_RX     = 'h48;
    localparam int OFS_MG_STAT   = 'h4C;

    localparam int SOFT_RST_BIT  = 11;
    localparam logic [31:0] DEF_MODE = 32'h0000A000;
    localparam logic [7:0]  DEF_TXBD = 8'h80;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_MODE, SEL_ISRC, SEL_IMASK, SEL_PKTLEN, SEL_TXBD,
        SEL_IPGT, SEL_IPGR1, SEL_IPGR2, SEL_COLL, SEL_CTRL, SEL_MAC0,
        SEL_MAC1, SEL_HASH0, SEL_HASH1, SEL_MG_MODE, SEL_MG_CMD,
        SEL_MG_ADDR, SEL_MG_TX, SEL_MG_RX, SEL_MG_STAT, SEL_BD
    } reg_sel_e;

    // Plain 32-bit storage words: select and reset value, index 0 is mode.
    localparam int NPLAIN = 15;
    localparam reg_sel_e PLAIN_SEL [NPLAIN] = '{
        SEL_MODE, SEL_PKTLEN, SEL_IPGT, SEL_IPGR1, SEL_IPGR2, SEL_COLL,
        SEL_CTRL, SEL_HASH0, SEL_HASH1, SEL_MG_MODE, SEL_MG_CMD,
        SEL_MG_ADDR, SEL_MG_TX, SEL_MG_RX, SEL_MG_STAT
    };
    localparam logic [31:0] PLAIN_DEF [NPLAIN] = '{
        DEF_MODE, 32'h003C0600, 32'h00000012, 32'h0000000C, 32'h00000012,
        32'h000F003F, 32'h0, 32'h0, 32'h0, 32'h00000064, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h0
    };

endpackage

// File: rtl/mac_regs_decode.sv
// Address decoder: maps a byte offset to a register select or to a
// descriptor RAM word. Assumes WIN_BASE lies above the register space.
module mac_regs_decode
    import mac_regs_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int WIN_BASE = 'h400,
    parameter int BD_WORDS = 256,
    localparam int BD_AW   = $clog2(BD_WORDS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o,
    output logic              legal_o,
    output logic [BD_AW-1:0]  bd_idx_o
);

    localparam int WIN_END = WIN_BASE + BD_WORDS * 4;

    int a_int;

    // Decode the offset; misaligned offsets never select anything.
    always_comb begin
        a_int    = int'(addr_i);
        sel_o    = SEL_NONE;
        bd_idx_o = BD_AW'((a_int - WIN_BASE) >> 2);
        if (addr_i[1:0] == 2'b00) begin
            if (a_int >= WIN_BASE && a_int < WIN_END) begin
                sel_o = SEL_BD;
            end else begin
                case (a_int)
                    OFS_MODE:    sel_o = SEL_MODE;
                    OFS_ISRC:    sel_o = SEL_ISRC;
                    OFS_IMASK:   sel_o = SEL_IMASK;
                    OFS_PKTLEN:  sel_o = SEL_PKTLEN;
                    OFS_TXBD:    sel_o = SEL_TXBD;
                    OFS_IPGT:    sel_o = SEL_IPGT;
                    OFS_IPGR1:   sel_o = SEL_IPGR1;
                    OFS_IPGR2:   sel_o = SEL_IPGR2;
                    OFS_COLL:    sel_o = SEL_COLL;
                    OFS_CTRL:    sel_o = SEL_CTRL;
                    OFS_MAC0:    sel_o = SEL_MAC0;
                    OFS_MAC1:    sel_o = SEL_MAC1;
                    OFS_HASH0:   sel_o = SEL_HASH0;
                    OFS_HASH1:   sel_o = SEL_HASH1;
                    OFS_MG_MODE: sel_o = SEL_MG_MODE;
                    OFS_MG_CMD:  sel_o = SEL_MG_CMD;
                    OFS_MG_ADDR: sel_o = SEL_MG_ADDR;
                    OFS_MG_TX:   sel_o = SEL_MG_TX;
                    OFS_MG_RX:   sel_o = SEL_MG_RX;
                    OFS_MG_STAT: sel_o = SEL_MG_STAT;
                    default:     sel_o = SEL_NONE;
                endcase
            end
        end
        legal_o = (sel_o != SEL_NONE);
    end

endmodule

// File: rtl/mac_regs_irq.sv
// Interrupt source and enable words. Source bits are set by engine events
// and cleared by writing 1; a set in the same cycle wins over a clear.
module mac_regs_irq #(
    parameter int INT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             src_wr_i,
    input  logic             mask_wr_i,
    input  logic [INT_W-1:0] wdata_i,
    input  logic [INT_W-1:0] int_set_i,
    output logic [INT_W-1:0] src_o,
    output logic [INT_W-1:0] mask_o,
    output logic             irq_o
);

    logic [INT_W-1:0] clr_bits;

    // Bits to clear this cycle from a source-word write.
    always_comb clr_bits = src_wr_i ? wdata_i : '0;

    // Source word: clear on write-one, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) src_o <= '0;
        else                      src_o <= (src_o & ~clr_bits) | int_set_i;
    end

    // Enable word: plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) mask_o <= '0;
        else if (mask_wr_i)       mask_o <= wdata_i;
    end

    // Request line: any enabled pending source.
    always_comb irq_o = |(src_o & mask_o);

endmodule

// File: rtl/mac_regs_bdram.sv
// Descriptor RAM: one write or read port, registered read data, no reset
// on the array (contents survive the soft reset).
module mac_regs_bdram #(
    parameter int BD_WORDS = 256,
    localparam int BD_AW   = $clog2(BD_WORDS)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic             re_i,
    input  logic [BD_AW-1:0] addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o
);

    logic [31:0] mem [BD_WORDS];

    // Write and registered read of one word.
    always_ff @(posedge clk) begin
        if (we_i) mem[addr_i] <= wdata_i;
        if (re_i) rdata_o <= mem[addr_i];
    end

endmodule

// File: rtl/mac_regs_top.sv
// MAC control register file top. Takes one request per cycle and answers
// it one cycle later. Assumes the engines treat the field outputs as
// quasi-static configuration.
module mac_regs_top
    import mac_regs_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int INT_W    = 7,
    parameter int WIN_BASE = 'h400,
    parameter int BD_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [INT_W-1:0]  int_set_i,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              irq_o,
    output logic [31:0]       mode_o,
    output logic [15:0]       pkt_min_o,
    output logic [15:0]       pkt_max_o,
    output logic [7:0]        txbd_num_o,
    output logic [7:0]        rx_bd_idx_o,
    output logic [47:0]       mac_addr_o
);

    localparam int BD_AW = $clog2(BD_WORDS);

    reg_sel_e          sel;
    logic              legal;
    logic [BD_AW-1:0]  bd_idx;
    logic              wr_ok;
    logic              rd_ok;
    logic              soft_rst;
    logic [31:0]       plain_q [NPLAIN];
    logic [5:0][7:0]   mac_q;
    logic [7:0]        txbd_q;
    logic [7:0]        rxidx_q;
    logic [INT_W-1:0]  isrc;
    logic [INT_W-1:0]  imask;
    logic [31:0]       rd_mux;
    logic [31:0]       reg_rd_q;
    logic              from_bd_q;
    logic [31:0]       bd_q;

    mac_regs_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .BD_WORDS(BD_WORDS)
    ) dec_i (
        .addr_i(req_addr), .sel_o(sel), .legal_o(legal), .bd_idx_o(bd_idx)
    );

    // Qualified strobes; the soft reset comes from a legal mode write.
    always_comb begin
        wr_ok    = req_valid && req_write && legal;
        rd_ok    = req_valid && !req_write && legal;
        soft_rst = wr_ok && (sel == SEL_MODE) && req_wdata[SOFT_RST_BIT];
    end

    // Plain storage words, one per table entry.
    for (genvar gi = 0; gi < NPLAIN; gi++) begin : g_plain
        // Hold one word, restore its default on either reset.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)                   plain_q[gi] <= PLAIN_DEF[gi];
            else if (wr_ok && sel == PLAIN_SEL[gi])   plain_q[gi] <= req_wdata;
        end
    end

    // Station address bytes, packed per the two address words.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)            mac_q <= '0;
        else if (wr_ok && sel == SEL_MAC0) mac_q[3:0] <= req_wdata;
        else if (wr_ok && sel == SEL_MAC1) mac_q[5:4] <= req_wdata[15:0];
    end

    // Descriptor count and receive index, loaded together.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            txbd_q  <= DEF_TXBD;
            rxidx_q <= DEF_TXBD;
        end else if (wr_ok && sel == SEL_TXBD) begin
            txbd_q  <= req_wdata[7:0];
            rxidx_q <= req_wdata[7:0];
        end
    end

    mac_regs_irq #(.INT_W(INT_W)) irq_i (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst),
        .src_wr_i(wr_ok && sel == SEL_ISRC),
        .mask_wr_i(wr_ok && sel == SEL_IMASK),
        .wdata_i(req_wdata[INT_W-1:0]), .int_set_i(int_set_i),
        .src_o(isrc), .mask_o(imask), .irq_o(irq_o)
    );

    mac_regs_bdram #(.BD_WORDS(BD_WORDS)) bd_i (
        .clk(clk), .we_i(wr_ok && sel == SEL_BD), .re_i(rd_ok && sel == SEL_BD),
        .addr_i(bd_idx), .wdata_i(req_wdata), .rdata_o(bd_q)
    );

    // Read multiplexer over all register words.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NPLAIN; i++) begin
            if (sel == PLAIN_SEL[i]) rd_mux = plain_q[i];
        end
        case (sel)
            SEL_ISRC:  rd_mux = 32'(isrc);
            SEL_IMASK: rd_mux = 32'(imask);
            SEL_TXBD:  rd_mux = {24'b0, txbd_q};
            SEL_MAC0:  rd_mux = mac_q[3:0];
            SEL_MAC1:  rd_mux = {16'b0, mac_q[5:4]};
            default:   ;
        endcase
    end

    // Response stage: valid, error, and data source one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            reg_rd_q  <= '0;
            from_bd_q <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !legal;
            reg_rd_q  <= (rd_ok && sel != SEL_BD) ? rd_mux : '0;
            from_bd_q <= rd_ok && sel == SEL_BD;
        end
    end

    // Outputs toward the engines and the bus.
    always_comb begin
        rsp_rdata   = from_bd_q ? bd_q : reg_rd_q;
        mode_o      = plain_q[0];
        pkt_min_o   = plain_q[1][31:16];
        pkt_max_o   = plain_q[1][15:0];
        txbd_num_o  = txbd_q;
        rx_bd_idx_o = rxidx_q;
        mac_addr_o  = mac_q;
    end

endmodule

// File: rtl/mac_regs_checker.sv
// Checker: protocol and side-effect properties of mac_regs_top, seen at
// its ports; attached by the bind below.
module mac_regs_checker
    import mac_regs_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic              irq_o,
    input logic [31:0]       mode_o,
    input logic [7:0]        rx_bd_idx_o
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);                                   // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);                                 // R10
    AST_ERR_ONLY_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);                                     // R9
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'h0));                          // R9
    AST_TXBD_LOADS_RXIDX: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_W'(OFS_TXBD))
        |=> (rx_bd_idx_o == $past(req_wdata[7:0])));                // R5
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_W'(OFS_MODE) && req_wdata[SOFT_RST_BIT])
        |=> (mode_o == DEF_MODE && rx_bd_idx_o == 8'h80 && !irq_o)); // R6

endmodule

bind mac_regs_top mac_regs_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_o(irq_o),
    .mode_o(mode_o), .rx_bd_idx_o(rx_bd_idx_o)
);

// File: tb/mac_regs_top_tb_top.sv
// Bench for mac_regs_top: a vector table of accesses with expected
// responses, then directed tests for interrupts, the index load and soft reset.
module mac_regs_top_tb_top;

    localparam int ADDR_W = 11;
    localparam int INT_W  = 7;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
        logic [31:0]       exp;
        logic              err;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 11'h000, 32'h0, 32'h0000A000, 1'b0, 4'd1},  // R1 mode
        '{1'b0, 11'h00C, 32'h0, 32'h003C0600, 1'b0, 4'd1},  // R1 limits
        '{1'b0, 11'h010, 32'h0, 32'h00000080, 1'b0, 4'd1},  // R1 count
        '{1'b0, 11'h014, 32'h0, 32'h00000012, 1'b0, 4'd1},  // R1 gap 1
        '{1'b0, 11'h018, 32'h0, 32'h0000000C, 1'b0, 4'd1},  // R1 gap 2
        '{1'b0, 11'h020, 32'h0, 32'h000F003F, 1'b0, 4'd1},  // R1 collision
        '{1'b0, 11'h038, 32'h0, 32'h00000064, 1'b0, 4'd1},  // R1 mgmt mode
        '{1'b0, 11'h030, 32'h0, 32'h00000000, 1'b0, 4'd1},  // R1 hash
        '{1'b1, 11'h028, 32'h44332211, 32'h0, 1'b0, 4'd7},  // R7
        '{1'b0, 11'h028, 32'h0, 32'h44332211, 1'b0, 4'd7},  // R7
        '{1'b1, 11'h02C, 32'hFFFF6655, 32'h0, 1'b0, 4'd7},  // R7
        '{1'b0, 11'h02C, 32'h0, 32'h00006655, 1'b0, 4'd7},  // R7 top half 0
        '{1'b1, 11'h414, 32'hDEADBEEF, 32'h0, 1'b0, 4'd8},  // R8 word 5
        '{1'b1, 11'h7FC, 32'h12345678, 32'h0, 1'b0, 4'd8},  // R8 last word
        '{1'b0, 11'h414, 32'h0, 32'hDEADBEEF, 1'b0, 4'd8},  // R8
        '{1'b0, 11'h7FC, 32'h0, 32'h12345678, 1'b0, 4'd8},  // R8
        '{1'b0, 11'h050, 32'h0, 32'h0, 1'b1, 4'd9},         // R9 unmapped
        '{1'b1, 11'h00D, 32'h00400800, 32'h0, 1'b1, 4'd9},  // R9 misaligned
        '{1'b0, 11'h00C, 32'h0, 32'h003C0600, 1'b0, 4'd9},  // R9 no effect
        '{1'b1, 11'h00C, 32'h00400800, 32'h0, 1'b0, 4'd2}   // R2
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [INT_W-1:0]  int_set_i = '0;
    logic              rsp_valid, rsp_err, irq_o;
    logic [31:0]       rsp_rdata, mode_o;
    logic [15:0]       pkt_min_o, pkt_max_o;
    logic [7:0]        txbd_num_o, rx_bd_idx_o;
    logic [47:0]       mac_addr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    mac_regs_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .int_set_i(int_set_i),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .irq_o(irq_o), .mode_o(mode_o), .pkt_min_o(pkt_min_o),
        .pkt_max_o(pkt_max_o), .txbd_num_o(txbd_num_o),
        .rx_bd_idx_o(rx_bd_idx_o), .mac_addr_o(mac_addr_o)
    );

    // 125 MHz clock: 8 ns period.
    always #4 clk = ~clk;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access; response sampled at the following falling edge.
    task automatic access(logic wr, logic [ADDR_W-1:0] a, logic [31:0] d,
                          logic [INT_W-1:0] ev);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        int_set_i = ev;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; int_set_i = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the field outputs; R10 no response while idle
        check("R1 mode_o", 64'(mode_o), 64'h0000A000);
        check("R1 rx idx", 64'(rx_bd_idx_o), 64'h80);
        check("R2 min/max", {32'b0, pkt_min_o, pkt_max_o}, {32'b0, 16'd60, 16'd1536});
        check("R4 irq low", 64'(irq_o), 64'h0);
        check("R10 idle", 64'(rsp_valid), 64'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, '0);
            check($sformatf("R%0d vec%0d valid", VECS[i].req, i), 64'(rsp_valid), 64'h1);
            check($sformatf("R%0d vec%0d err", VECS[i].req, i), 64'(rsp_err), 64'(VECS[i].err));
            check($sformatf("R%0d vec%0d data", VECS[i].req, i), 64'(rsp_rdata), 64'(VECS[i].exp));
        end
        @(negedge clk);
        check("R9 error one cycle", 64'(rsp_err), 64'h0);
        check("R10 no stray rsp", 64'(rsp_valid), 64'h0);
        check("R2 new limits", {32'b0, pkt_min_o, pkt_max_o}, {32'b0, 16'h0040, 16'h0800});
        check("R7 station address", 64'(mac_addr_o), 64'h0000_6655_4433_2211);

        // R3/R4: events, enable, write-one-to-clear, set wins over clear
        access(1'b0, 11'h004, 32'h0, 7'h05);
        check("R4 masked off", 64'(irq_o), 64'h0);
        access(1'b0, 11'h004, 32'h0, '0);
        check("R3 source set", 64'(rsp_rdata), 64'h5);
        access(1'b1, 11'h008, 32'h4, '0);
        check("R4 irq enabled", 64'(irq_o), 64'h1);
        access(1'b1, 11'h004, 32'h4, '0);
        check("R4 irq after clear", 64'(irq_o), 64'h0);
        access(1'b0, 11'h004, 32'h0, '0);
        check("R3 other bit kept", 64'(rsp_rdata), 64'h1);
        access(1'b1, 11'h004, 32'h1, 7'h01);
        access(1'b0, 11'h004, 32'h0, '0);
        check("R3 set wins", 64'(rsp_rdata), 64'h1);
        access(1'b1, 11'h004, 32'h0, 7'h04);
        check("R4 irq from event", 64'(irq_o), 64'h1);

        // R5: count keeps low byte and loads the receive index
        access(1'b1, 11'h010, 32'h000001C3, '0);
        check("R5 rx idx", 64'(rx_bd_idx_o), 64'hC3);
        check("R5 count out", 64'(txbd_num_o), 64'hC3);
        access(1'b0, 11'h010, 32'h0, '0);
        check("R5 count read", 64'(rsp_rdata), 64'hC3);

        // R6: soft reset through the mode word
        access(1'b1, 11'h000, 32'h00000800, '0);
        check("R6 mode", 64'(mode_o), 64'h0000A000);
        check("R6 rx idx", 64'(rx_bd_idx_o), 64'h80);
        check("R6 irq", 64'(irq_o), 64'h0);
        check("R6 address", 64'(mac_addr_o), 64'h0);
        check("R6 limits", {32'b0, pkt_min_o, pkt_max_o}, {32'b0, 16'd60, 16'd1536});
        access(1'b0, 11'h008, 32'h0, '0);
        check("R6 enable cleared", 64'(rsp_rdata), 64'h0);
        access(1'b0, 11'h414, 32'h0, '0);
        check("R6 R8 ram kept", 64'(rsp_rdata), 64'hDEADBEEF);
        access(1'b1, 11'h000, 32'h00001234, '0);
        check("R6 plain mode write", 64'(mode_o), 64'h00001234);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule